// File: doc/BRIEF.md
# Base-2 Exponential Approximator

This block turns a signed fixed-point exponent into an approximate power of two. It takes the input apart by bit position. The upper bits are a two's-complement whole-number part and the lower bits are a fraction. The top few fraction bits index a small table of antilog values. A leading one is placed in front of the table value, so the mantissa always lies in [1.0, 2.0). A shifter then moves the mantissa left or right by the whole-number part. There is no iterative refinement, so the accuracy is set by the table size.

An exponent in another log base can be handled in the same pass. When the scale request is raised with a sample, the input is first multiplied by a fixed constant that converts it to base 2. With the default constant, log2(e), the block computes e^x. Results whose exponent falls outside the output range are clamped, and a flag reports which way they were clamped. The pipeline takes a new sample every cycle. Each result appears two clock edges after its input.

Default format: the input is 16 bits, with 6 whole-number bits and 10 fraction bits. The output is an unsigned 16-bit value with 8 fraction bits. The table has 16 entries, each holding 12 mantissa fraction bits.

Top module: `exp2_approx`

## Requirements
- R1: A sample presented with `in_valid` high at a rising edge produces `out_valid` high exactly two rising edges later; no other cycle shows `out_valid` high.
- R2: The whole-number part n is `x[15:10]` read as two's complement, and the table index is `x[9:6]`; no arithmetic is applied to form them.
- R3: When n >= 8, `out_y` is 16'hFFFF and `out_ovf` is 1 with `out_unf` 0.
- R4: When n < -8, `out_y` is 0 and `out_unf` is 1 with `out_ovf` 0.
- R5: Table entry k holds round((2^(k/16) - 1) * 4096). The mantissa is 4096 + entry, read with 12 fraction bits.
- R6: For -8 <= n <= 7, `out_y` is floor(mantissa * 2^n * 256), which is never zero, and both flags are 0.
- R7: Input bits `x[5:0]` have no effect on the result.
- R8: With `in_scale` high, the input is first replaced by floor(x * 23637 / 2^14), clamped to [-32768, 32767]; the clamped value then goes through R2 to R6.
- R9: While `rst_n` is low, `out_valid`, `out_y`, `out_ovf` and `out_unf` are all 0, and a sample in flight when reset arrives is discarded.
- R10: `out_ovf` and `out_unf` are never high together, and both are 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_scale | input | 1 | Apply the base-conversion constant to this sample |
| in_x | input | 16 | Signed exponent, 6 whole-number bits and 10 fraction bits |
| out_valid | output | 1 | Result strobe |
| out_y | output | 16 | Unsigned result, 8 fraction bits |
| out_ovf | output | 1 | Result clamped to full scale |
| out_unf | output | 1 | Result clamped to zero |

## Verification
The bench sweeps all sixteen table slots with the exponent chosen so that the shift is zero. At that exponent the raw mantissa appears unchanged at the output, so an entry that was rounded wrongly or addressed with the wrong bits shows up as a one-LSB or larger error.

It also goes after the edges of the exponent range:
- At n = 7 and n = 8, a design with an off-by-one overflow compare would either saturate a valid result or wrap it.
- At n = -8 and n = -9, a wrong underflow compare would either zero the smallest non-zero result or let a truncated value through.

Further checks cover inputs that differ only in the bits below the table index, with and without the conversion multiply. The multiply checks include both clamping extremes, where a design that dropped the sign or skipped the clamp would wrap around. They also include a negative value that is not a whole number, which exposes truncation toward zero instead of flooring.

// File: rtl/exp2_pkg.sv
package exp2_pkg;

    // Antilog table entry: (2^(k / 2^addr_w) - 1) scaled by 2^mant_w, rounded.
    function automatic int antilog_entry(input int k, input int addr_w, input int mant_w);
        real r;
        r = (2.0 ** (real'(k) / real'(1 << addr_w)) - 1.0) * real'(1 << mant_w);
        return $rtoi(r + 0.5);
    endfunction

endpackage

// File: rtl/exp2_prescale.sv
module exp2_prescale #(
    parameter int IN_W     = 16,
    parameter int K_W      = 16,
    parameter int K_FRAC_W = 14,
    parameter int K_VAL    = 23637
) (
    input  logic signed [IN_W-1:0] x_i,
    input  logic                   en_i,
    output logic signed [IN_W-1:0] x_o
);
    localparam int PW = IN_W + K_W + 1;
    localparam logic [K_W:0] K_U = {1'b0, K_W'(K_VAL)};
    localparam logic signed [PW-1:0] MAXV = $signed({{(PW-IN_W+1){1'b0}}, {(IN_W-1){1'b1}}});
    localparam logic signed [PW-1:0] MINV = $signed({{(PW-IN_W+1){1'b1}}, {(IN_W-1){1'b0}}});

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;
    logic signed [IN_W-1:0] clamped;

    always_comb begin
        prod    = $signed(PW'(x_i)) * $signed(PW'(K_U));
        shifted = prod >>> K_FRAC_W;
        if (shifted > MAXV) begin
            clamped = {1'b0, {(IN_W-1){1'b1}}};
        end else if (shifted < MINV) begin
            clamped = {1'b1, {(IN_W-1){1'b0}}};
        end else begin
            clamped = shifted[IN_W-1:0];
        end
        x_o = en_i ? clamped : x_i;
    end
endmodule

// File: rtl/exp2_antilog_rom.sv
module exp2_antilog_rom #(
    parameter int ADDR_W = 4,
    parameter int MANT_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [MANT_W-1:0] frac_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [MANT_W-1:0] entries [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam int VAL = exp2_pkg::antilog_entry(k, ADDR_W, MANT_W);
        assign entries[k] = MANT_W'(VAL);
    end

    assign frac_o = entries[addr_i];
endmodule

// File: rtl/exp2_shifter.sv
module exp2_shifter #(
    parameter int INT_W      = 6,
    parameter int MANT_W     = 12,
    parameter int OUT_W      = 16,
    parameter int OUT_FRAC_W = 8
) (
    input  logic signed [INT_W-1:0] n_i,
    input  logic [MANT_W:0]         mant_i,
    output logic [OUT_W-1:0]        y_o,
    output logic                    ovf_o,
    output logic                    unf_o
);
    localparam int OUT_INT_W = OUT_W - OUT_FRAC_W;
    localparam int WW        = OUT_W + MANT_W;
    localparam int SH_W      = $clog2(OUT_W);

    logic [SH_W-1:0] sh;
    logic [WW-1:0]   wide;
    logic            unused_low;
    int              n_int;

    always_comb begin
        n_int = int'(n_i);
        ovf_o = 1'b0;
        unf_o = 1'b0;
        sh    = '0;
        if (n_int >= OUT_INT_W) begin
            ovf_o = 1'b1;
        end else if (n_int < -OUT_FRAC_W) begin
            unf_o = 1'b1;
        end else begin
            sh = SH_W'(n_int + OUT_FRAC_W);
        end
        wide = WW'(mant_i) << sh;
        if (ovf_o) begin
            y_o = '1;
        end else if (unf_o) begin
            y_o = '0;
        end else begin
            y_o = wide[MANT_W +: OUT_W];
        end
    end

    assign unused_low = ^wide[MANT_W-1:0];
endmodule

// File: rtl/exp2_approx.sv
module exp2_approx #(
    parameter int IN_INT_W   = 6,
    parameter int IN_FRAC_W  = 10,
    parameter int ADDR_W     = 4,
    parameter int MANT_W     = 12,
    parameter int OUT_W      = 16,
    parameter int OUT_FRAC_W = 8,
    parameter bit HAS_SCALE  = 1'b1,
    parameter int K_W        = 16,
    parameter int K_FRAC_W   = 14,
    parameter int K_VAL      = 23637
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_scale,
    input  logic [IN_INT_W+IN_FRAC_W-1:0] in_x,
    output logic                          out_valid,
    output logic [OUT_W-1:0]              out_y,
    output logic                          out_ovf,
    output logic                          out_unf
);
    localparam int IN_W  = IN_INT_W + IN_FRAC_W;
    localparam int DROP_W = IN_FRAC_W - ADDR_W;

    typedef struct packed {
        logic                       vld;
        logic signed [IN_INT_W-1:0] ipart;
        logic [ADDR_W-1:0]          idx;
    } stage_a_t;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] y;
        logic             ovf;
        logic             unf;
    } stage_b_t;

    stage_a_t a_d, a_q;
    stage_b_t b_d, b_q;

    logic signed [IN_W-1:0] x_eff;
    logic [MANT_W-1:0]      rom_frac;
    logic [OUT_W-1:0]       sh_y;
    logic                   sh_ovf;
    logic                   sh_unf;

    if (HAS_SCALE) begin : g_scale
        exp2_prescale #(
            .IN_W     (IN_W),
            .K_W      (K_W),
            .K_FRAC_W (K_FRAC_W),
            .K_VAL    (K_VAL)
        ) u_prescale (
            .x_i  ($signed(in_x)),
            .en_i (in_scale),
            .x_o  (x_eff)
        );
    end else begin : g_noscale
        logic unused_scale;
        assign unused_scale = in_scale;
        assign x_eff        = $signed(in_x);
    end

    if (DROP_W > 0) begin : g_drop
        logic unused_low;
        assign unused_low = ^x_eff[DROP_W-1:0];
    end

    exp2_antilog_rom #(
        .ADDR_W (ADDR_W),
        .MANT_W (MANT_W)
    ) u_rom (
        .addr_i (a_q.idx),
        .frac_o (rom_frac)
    );

    exp2_shifter #(
        .INT_W      (IN_INT_W),
        .MANT_W     (MANT_W),
        .OUT_W      (OUT_W),
        .OUT_FRAC_W (OUT_FRAC_W)
    ) u_shift (
        .n_i    (a_q.ipart),
        .mant_i ({1'b1, rom_frac}),
        .y_o    (sh_y),
        .ovf_o  (sh_ovf),
        .unf_o  (sh_unf)
    );

    always_comb begin
        a_d     = a_q;
        a_d.vld = in_valid;
        if (in_valid) begin
            a_d.ipart = x_eff[IN_W-1 -: IN_INT_W];
            a_d.idx   = x_eff[IN_FRAC_W-1 -: ADDR_W];
        end

        b_d     = b_q;
        b_d.vld = a_q.vld;
        b_d.ovf = 1'b0;
        b_d.unf = 1'b0;
        if (a_q.vld) begin
            b_d.y   = sh_y;
            b_d.ovf = sh_ovf;
            b_d.unf = sh_unf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= a_d;
            b_q <= b_d;
        end
    end

    assign out_valid = b_q.vld;
    assign out_y     = b_q.y;
    assign out_ovf   = b_q.ovf;
    assign out_unf   = b_q.unf;
endmodule

// File: rtl/exp2_approx_chk.sv
module exp2_approx_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_y,
    input logic             out_ovf,
    input logic             out_unf
);
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    assert_ovf_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> (out_y == {OUT_W{1'b1}}));

    assert_unf_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_unf |-> (out_y == '0));

    assert_nonzero_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_unf) |-> (out_y != '0));

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({out_ovf, out_unf}) <= 1);

    assert_flags_need_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_ovf && !out_unf));
endmodule

bind exp2_approx exp2_approx_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_y     (out_y),
    .out_ovf   (out_ovf),
    .out_unf   (out_unf)
);

// File: tb/exp2_approx_tb.sv
`timescale 1ns/1ps
module exp2_approx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_scale = 1'b0;
    logic [15:0] in_x = '0;
    logic        out_valid;
    logic [15:0] out_y;
    logic        out_ovf;
    logic        out_unf;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] y;
        bit          ovf;
        bit          unf;
        string       tag;
        int          issue;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    exp2_approx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_scale  (in_scale),
        .in_x      (in_x),
        .out_valid (out_valid),
        .out_y     (out_y),
        .out_ovf   (out_ovf),
        .out_unf   (out_unf)
    );

    function automatic int tbl_val(int k);
        return $rtoi((2.0 ** (real'(k) / 16.0) - 1.0) * 4096.0 + 0.5);
    endfunction

    function automatic exp_t model(logic [15:0] x, bit sc, string tag);
        exp_t   e;
        longint xs;
        int     n;
        int     idx;
        longint m;
        xs = longint'($signed(x));
        if (sc) begin
            xs = (xs * 23637) >>> 14;
            if (xs > 32767) xs = 32767;
            if (xs < -32768) xs = -32768;
        end
        n   = int'(xs) >>> 10;
        idx = (int'(xs) >> 6) & 15;
        e.ovf = 1'b0;
        e.unf = 1'b0;
        e.tag = tag;
        if (n >= 8) begin
            e.y = 16'hFFFF;
            e.ovf = 1'b1;
        end else if (n < -8) begin
            e.y = 16'h0000;
            e.unf = 1'b1;
        end else begin
            m = 64'd4096 + longint'(tbl_val(idx));
            e.y = 16'((m << (n + 8)) >> 12);
        end
        return e;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic send(logic [15:0] x, bit sc, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_scale = sc;
        in_x     = x;
        e = model(x, sc, tag);
        e.issue = cyc;
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_scale = 1'b0;
            in_x     = 16'h5A5A;
        end
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R1", "unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc - e.issue == 2, "R1", "latency", cyc - e.issue, 2);
                    check(out_y == e.y, e.tag, "out_y", out_y, e.y);
                    check(out_ovf == e.ovf && out_unf == e.unf, e.tag, "flags",
                          {out_ovf, out_unf}, {e.ovf, e.unf});
                end
            end else begin
                check(!out_ovf && !out_unf, "R10", "flags while idle",
                      {out_ovf, out_unf}, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: state under reset
        check(out_valid == 0, "R9", "out_valid in reset", out_valid, 0);
        check(out_y == 0, "R9", "out_y in reset", out_y, 0);
        check(!out_ovf && !out_unf, "R9", "flags in reset", {out_ovf, out_unf}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R9: sample in flight is discarded by reset
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = 16'h0400;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check(out_valid == 0, "R9", "in-flight sample after reset", out_valid, 0);
        @(negedge clk);
        check(out_valid == 0, "R9", "in-flight sample after reset", out_valid, 0);
        rst_n = 1'b1;
        idle(2);

        // R6: basic points, streamed back to back
        send(16'h0000, 0, "R6");
        send(16'h0400, 0, "R6");
        send(16'hFC00, 0, "R6");
        send(16'h0200, 0, "R6");
        send(16'h1FC0, 0, "R6");  // n=7, top table slot
        idle(3);

        // R2: negative fraction bits, fixed split
        send(16'hFFFF, 0, "R2");
        send(16'hF7C0, 0, "R2");
        send(16'h0B80, 0, "R2");
        idle(1);

        // R3 / R4 boundaries
        send(16'h2000, 0, "R3");  // n=8
        send(16'h7FFF, 0, "R3");
        send(16'hE000, 0, "R6");  // n=-8, smallest non-zero
        send(16'hDFFF, 0, "R4");  // n=-9
        send(16'h8000, 0, "R4");
        idle(2);

        // R5: every table slot with n=4 so the mantissa reaches the output unshifted
        for (int k = 0; k < 16; k++) begin
            send(16'(16'h1000 + k * 64), 0, "R5");
        end
        idle(2);

        // R7: bits below the table index are ignored
        send(16'h0A40, 0, "R7");
        send(16'h0A7F, 0, "R7");
        send(16'hF2C0, 0, "R7");
        send(16'hF2FF, 0, "R7");
        idle(2);

        // R8: base conversion multiply, including both clamps and a negative non-integer
        send(16'h0400, 1, "R8");
        send(16'h0000, 1, "R8");
        send(16'hFC00, 1, "R8");
        send(16'hFA37, 1, "R8");
        send(16'h1400, 1, "R8");
        send(16'h7FFF, 1, "R8");
        send(16'h8000, 1, "R8");
        idle(1);
        send(16'h0400, 0, "R8");  // same code without scaling
        idle(6);

        check(sb.size() == 0, "R1", "results outstanding", sb.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule